// File: doc/BRIEF.md
# Receive Message DMA Read Port

This block hands bytes of received HDLC messages from per-channel receive buffers to an external DMA controller over the shared microprocessor data bus. Software programs a single control register: an enable, a bus-mode bit, a channel-reset trigger and a three-bit channel code. While enabled with a legal channel code, the block pulls its active-low request line low once the chosen buffer reports at least one complete message. The controller answers with an active-low acknowledge and then strobes the bus. Each strobe takes one byte.

The strobe that moves data depends on the bus mode. In read-strobe mode the RD pin strobes and WR is ignored. In direction mode RD only marks the cycle direction and WR strobes. The pins are asynchronous to the block clock. They are synchronised, and each falling edge of the selected strobe seen while acknowledge is low captures the head byte of the selected buffer onto the data output and pops it. Request is released once the byte flagged as the end of a message is taken. A new request follows only after acknowledge has been released and another complete message waits.

Top module: `rxdma_read_port`

## Requirements
- R1: After reset the register reads 0x00, the request output is high, the bus output enable is low and no buffer pop is issued.
- R2: The register holds enable in bit 0, bus mode in bit 1, channel-reset trigger in bit 2 and the channel code in bits 6:4. All of them read back as written, and bits 3 and 7 read as 0.
- R3: With enable at 0 the request stays high even when a complete message is buffered. Clearing enable ends a transfer in progress with request high.
- R4: A request is raised only while the selected buffer reports a complete message. Buffered bytes that do not yet include an end-of-message byte raise no request.
- R5: In bus mode 0, each falling edge of RD while acknowledge is low presents the next byte on the data output and pops exactly one byte from the selected buffer. Pulses on WR have no effect.
- R6: In bus mode 1, WR is the data strobe, with the same one-byte-per-falling-edge behaviour. Pulses on RD have no effect.
- R7: Channel code 000 serves buffer 0 and code 010 serves buffer 2. Only the selected buffer is popped.
- R8: The reserved channel codes (001, 011 and 1xx) block all requests.
- R9: Request goes high once the end-of-message byte has been taken. It is raised again only after acknowledge has returned high and another complete message waits.
- R10: The bus output enable is high only while acknowledge is low and the selected strobe is low during a request or transfer. Otherwise it is low.
- R11: Writing the channel-reset bit from 0 to 1 aborts the transfer: request goes high until acknowledge is released. Writing 1 while the bit already holds 1 leaves a transfer undisturbed.
- R12: Strobes while acknowledge is high pop nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| dma_req_n | output | 1 | Active-low transfer request to the DMA controller |
| dma_ack_n | input | 1 | Active-low acknowledge from the DMA controller |
| rd_n | input | 1 | Bus RD pin: read strobe or direction |
| wr_n | input | 1 | Bus WR pin: data strobe in direction mode |
| bus_dout | output | 8 | Byte presented on the data bus |
| bus_oe | output | 1 | Data bus output enable |
| buf_data | input | NCH*8 | Head byte of each channel buffer |
| buf_last | input | NCH | Head byte of each buffer ends a message |
| buf_msg_rdy | input | NCH | Buffer holds at least one complete message |
| buf_pop | output | NCH | Pop the head byte of a buffer, one-hot |

## Verification
A complete message raises request one clock after the buffer reports it. The acknowledge and strobe pins pass two synchroniser stages, so a pop is issued on the second clock edge after a strobe falls and the byte is on the data output after the third. The request rises at the same edge that takes the end-of-message byte, and a register write that triggers a channel reset takes effect two edges after the write. The bench drives inputs on the falling clock edge and samples outputs at least one full cycle after each due edge, so every check observes a settled value.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int REG_W   = 8;
  localparam int CH_W    = 3;
  localparam int EN_BIT  = 0;
  localparam int DIR_BIT = 1;
  localparam int RST_BIT = 2;
  localparam int CH_LSB  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2
  } dma_state_e;
endpackage

// File: rtl/rxdma_sync.sv
module rxdma_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/rxdma_ctrl_reg.sv
module rxdma_ctrl_reg
  import rxdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             en,
  output logic             dir_mode,
  output logic [CH_W-1:0]  chsel,
  output logic             chan_rst
);
  logic            en_q, dir_q, rst_bit_q, pulse_q;
  logic [CH_W-1:0] ch_q;
  logic            en_d, dir_d, rst_bit_d, pulse_d;
  logic [CH_W-1:0] ch_d;

  always_comb begin
    en_d      = en_q;
    dir_d     = dir_q;
    rst_bit_d = rst_bit_q;
    ch_d      = ch_q;
    pulse_d   = 1'b0;
    if (we) begin
      en_d      = wdata[EN_BIT];
      dir_d     = wdata[DIR_BIT];
      rst_bit_d = wdata[RST_BIT];
      ch_d      = wdata[CH_LSB +: CH_W];
      pulse_d   = wdata[RST_BIT] & ~rst_bit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      dir_q     <= 1'b0;
      rst_bit_q <= 1'b0;
      ch_q      <= '0;
      pulse_q   <= 1'b0;
    end else begin
      en_q      <= en_d;
      dir_q     <= dir_d;
      rst_bit_q <= rst_bit_d;
      ch_q      <= ch_d;
      pulse_q   <= pulse_d;
    end
  end

  always_comb begin
    rdata                  = '0;
    rdata[EN_BIT]          = en_q;
    rdata[DIR_BIT]         = dir_q;
    rdata[RST_BIT]         = rst_bit_q;
    rdata[CH_LSB +: CH_W]  = ch_q;
  end

  assign en       = en_q;
  assign dir_mode = dir_q;
  assign chsel    = ch_q;
  assign chan_rst = pulse_q;
endmodule

// File: rtl/rxdma_fsm.sv
module rxdma_fsm
  import rxdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       code_ok,
  input  logic       chan_rst,
  input  logic       msg_rdy,
  input  logic       ack_s,
  input  logic       strb_fall,
  input  logic       head_last,
  output dma_state_e state,
  output logic       pop
);
  dma_state_e state_q, state_d;

  assign pop = (state_q == ST_XFER) & en & code_ok & ~chan_rst & ~ack_s & strb_fall;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (chan_rst)                      state_d = ST_DRAIN;
        else if (en && code_ok && msg_rdy) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (chan_rst)                state_d = ST_DRAIN;
        else if (!en || !code_ok)    state_d = ST_IDLE;
        else if (pop && head_last)   state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (ack_s && !chan_rst)      state_d = ST_IDLE;
      end
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/rxdma_read_port.sv
module rxdma_read_port
  import rxdma_pkg::*;
#(
  parameter int          NCH        = 4,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  VALID_MASK = 8'h05
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  dma_req_n,
  input  logic                  dma_ack_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  output logic [DATA_W-1:0]     bus_dout,
  output logic                  bus_oe,
  input  logic [NCH*DATA_W-1:0] buf_data,
  input  logic [NCH-1:0]        buf_last,
  input  logic [NCH-1:0]        buf_msg_rdy,
  output logic [NCH-1:0]        buf_pop
);
  logic            en, dir_mode, chan_rst, code_ok;
  logic [CH_W-1:0] chsel;
  logic            ack_s, rd_s, wr_s, strb_s, strb_prev_q, strb_fall;
  logic [2:0]      pins_s;
  logic [NCH-1:0]  sel_vec;
  logic [DATA_W-1:0] head_data;
  logic            head_last, msg_rdy, pop;
  logic [DATA_W-1:0] dout_q;
  dma_state_e      state;

  rxdma_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .rdata(reg_rdata),
    .en(en), .dir_mode(dir_mode), .chsel(chsel), .chan_rst(chan_rst)
  );

  rxdma_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async({dma_ack_n, wr_n, rd_n}), .q_sync(pins_s)
  );
  assign {ack_s, wr_s, rd_s} = pins_s;

  assign strb_s = dir_mode ? wr_s : rd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_prev_q <= 1'b1;
    else        strb_prev_q <= strb_s;
  end
  assign strb_fall = strb_prev_q & ~strb_s;

  assign code_ok = VALID_MASK[chsel] && (int'(chsel) < NCH);

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign sel_vec[c] = code_ok && (chsel == CH_W'(c));
    assign buf_pop[c] = pop & sel_vec[c];
  end

  always_comb begin
    head_data = '0;
    head_last = 1'b0;
    msg_rdy   = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (sel_vec[c]) begin
        head_data = head_data | buf_data[c*DATA_W +: DATA_W];
        head_last = head_last | buf_last[c];
        msg_rdy   = msg_rdy | buf_msg_rdy[c];
      end
    end
  end

  rxdma_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .code_ok(code_ok), .chan_rst(chan_rst),
    .msg_rdy(msg_rdy), .ack_s(ack_s), .strb_fall(strb_fall), .head_last(head_last),
    .state(state), .pop(pop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dout_q <= '0;
    else if (pop) dout_q <= head_data;
  end

  assign bus_dout  = dout_q;
  assign dma_req_n = (state != ST_XFER);
  assign bus_oe    = (state != ST_IDLE) & ~dma_ack_n & ~(dir_mode ? wr_n : rd_n);
endmodule

// File: rtl/rxdma_read_port_chk.sv
module rxdma_read_port_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dma_req_n,
  input logic           dma_ack_n,
  input logic [NCH-1:0] buf_pop,
  input logic           en,
  input logic           code_ok,
  input logic           chan_rst,
  input logic           head_last
);
  // R3: a disabled port never holds a request
  a_r3_disabled_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> dma_req_n);

  // R8: a reserved channel code never holds a request
  a_r8_reserved_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok |=> dma_req_n);

  // R7: at most one buffer popped at a time
  a_r7_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_pop));

  // R12: a pop needs acknowledge low two edges earlier at the pin
  a_r12_pop_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|buf_pop) |-> ($past(dma_ack_n, 2) == 1'b0));

  // R9: taking the end-of-message byte releases the request
  a_r9_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ((|buf_pop) && head_last) |=> dma_req_n);

  // R11: a channel reset drops the request
  a_r11_reset_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> dma_req_n);
endmodule

bind rxdma_read_port rxdma_read_port_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req_n(dma_req_n), .dma_ack_n(dma_ack_n),
  .buf_pop(buf_pop), .en(en), .code_ok(code_ok), .chan_rst(chan_rst),
  .head_last(head_last)
);

// File: tb/sim_rxdma_read_port.sv
`timescale 1ns/1ps
module sim_rxdma_read_port;
  localparam int NCH = 4;
  localparam logic [7:0] C_EN  = 8'h01;
  localparam logic [7:0] C_DIR = 8'h02;
  localparam logic [7:0] C_RST = 8'h04;
  localparam logic [7:0] C_CH2 = 8'h20;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic dma_req_n, dma_ack_n, rd_n, wr_n, bus_oe;
  logic [7:0] bus_dout;
  logic [NCH*8-1:0] buf_data;
  logic [NCH-1:0] buf_last, buf_msg_rdy, buf_pop;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rxdma_read_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_req_n(dma_req_n), .dma_ack_n(dma_ack_n),
    .rd_n(rd_n), .wr_n(wr_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .buf_data(buf_data), .buf_last(buf_last), .buf_msg_rdy(buf_msg_rdy),
    .buf_pop(buf_pop)
  );

  // buffer model
  logic [7:0] mem [NCH][32];
  logic       lst [NCH][32];
  int wp [NCH];
  int rp [NCH];
  int nin [NCH];
  int nout [NCH];

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (buf_pop[c]) begin
        if (lst[c][rp[c] % 32]) nout[c] <= nout[c] + 1;
        rp[c] <= rp[c] + 1;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      buf_data[c*8 +: 8] = mem[c][rp[c] % 32];
      buf_last[c]        = lst[c][rp[c] % 32];
      buf_msg_rdy[c]     = nin[c] > nout[c];
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push_byte(input int ch, input logic [7:0] v, input logic last);
    mem[ch][wp[ch] % 32] = v;
    lst[ch][wp[ch] % 32] = last;
    wp[ch] = wp[ch] + 1;
    if (last) nin[ch] = nin[ch] + 1;
  endtask

  task automatic push_msg(input int ch, input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) push_byte(ch, base + 8'(i), i == n - 1);
  endtask

  task automatic wr_reg(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    tick(1);
    reg_we = 1'b0;
  endtask

  // one strobe pulse on the selected pin, byte checked on the bus
  task automatic read_byte(input logic dir, input logic [7:0] exp, input string tag);
    chk({tag, " R10 oe low while strobe high"}, bus_oe, 1'b0);
    if (dir) wr_n = 1'b0; else rd_n = 1'b0;
    tick(4);
    chk({tag, " data"}, bus_dout, exp);
    chk({tag, " R10 oe high while strobe low"}, bus_oe, 1'b1);
    if (dir) wr_n = 1'b1; else rd_n = 1'b1;
    tick(3);
  endtask

  task automatic read_msg(input logic dir, input logic [7:0] base, input int n, input string tag);
    chk({tag, " request low"}, dma_req_n, 1'b0);
    dma_ack_n = 1'b0;
    tick(3);
    for (int i = 0; i < n; i++) read_byte(dir, base + 8'(i), tag);
    chk({tag, " R9 request high after last byte"}, dma_req_n, 1'b1);
    dma_ack_n = 1'b1;
    tick(3);
  endtask

  task automatic t_reset();
    chk("R1 reg after reset", reg_rdata, 8'h00);
    chk("R1 req after reset", dma_req_n, 1'b1);
    chk("R1 oe after reset", bus_oe, 1'b0);
    chk("R1 pop after reset", buf_pop, 4'h0);
  endtask

  task automatic t_regs();
    wr_reg(8'hFF);
    chk("R2 unused bits read 0", reg_rdata, 8'h77);
    wr_reg(8'h52);
    chk("R2 field readback", reg_rdata, 8'h52);
    wr_reg(8'h00);
    chk("R2 cleared", reg_rdata, 8'h00);
    tick(4);
  endtask

  task automatic t_disabled();
    push_msg(0, 2, 8'h10);
    tick(4);
    chk("R3 no request while disabled", dma_req_n, 1'b1);
    wr_reg(C_EN);
    tick(2);
    read_msg(1'b0, 8'h10, 2, "R3 enabled read");
  endtask

  task automatic t_partial();
    push_byte(0, 8'h20, 1'b0);
    push_byte(0, 8'h21, 1'b0);
    tick(4);
    chk("R4 no request for partial message", dma_req_n, 1'b1);
    push_byte(0, 8'h22, 1'b1);
    tick(2);
    read_msg(1'b0, 8'h20, 3, "R4 completed message");
  endtask

  task automatic t_read_strobe();
    push_msg(0, 3, 8'h30);
    tick(2);
    // R12: strobe without acknowledge
    rd_n = 1'b0; tick(4);
    chk("R12 oe low without ack", bus_oe, 1'b0);
    rd_n = 1'b1; tick(3);
    dma_ack_n = 1'b0; tick(3);
    // R5: WR pulse ignored in read-strobe mode
    wr_n = 1'b0; tick(4); wr_n = 1'b1; tick(3);
    chk("R5 request held after WR pulse", dma_req_n, 1'b0);
    for (int i = 0; i < 3; i++) read_byte(1'b0, 8'h30 + 8'(i), "R5 R12 read strobe");
    chk("R9 request high after last", dma_req_n, 1'b1);
    dma_ack_n = 1'b1; tick(4);
    chk("R9 no re-request when empty", dma_req_n, 1'b1);
  endtask

  task automatic t_dir_mode();
    wr_reg(C_EN | C_DIR);
    push_msg(0, 2, 8'h40);
    tick(2);
    dma_ack_n = 1'b0; tick(3);
    rd_n = 1'b0; tick(4); rd_n = 1'b1; tick(3);
    chk("R6 request held after RD pulse", dma_req_n, 1'b0);
    read_byte(1'b1, 8'h40, "R6 write strobe");
    read_byte(1'b1, 8'h41, "R6 write strobe");
    chk("R6 request high after last", dma_req_n, 1'b1);
    dma_ack_n = 1'b1; tick(3);
    wr_reg(C_EN);
  endtask

  task automatic t_chan_sel();
    push_msg(0, 2, 8'hA0);
    push_msg(2, 3, 8'hC0);
    wr_reg(C_EN | C_CH2);
    tick(2);
    read_msg(1'b0, 8'hC0, 3, "R7 channel 2");
    chk("R7 channel 0 untouched", nout[0] < nin[0], 1'b1);
    wr_reg(C_EN);
    tick(2);
    read_msg(1'b0, 8'hA0, 2, "R7 channel 0");
  endtask

  task automatic t_reserved();
    push_msg(1, 2, 8'hB0);
    push_msg(3, 2, 8'hD0);
    wr_reg(C_EN | 8'h10);
    tick(4);
    chk("R8 code 001 blocks", dma_req_n, 1'b1);
    wr_reg(C_EN | 8'h30);
    tick(4);
    chk("R8 code 011 blocks", dma_req_n, 1'b1);
    wr_reg(C_EN | 8'h40);
    tick(4);
    chk("R8 code 100 blocks", dma_req_n, 1'b1);
    wr_reg(C_EN);
    tick(3);
  endtask

  task automatic t_back_to_back();
    push_msg(0, 2, 8'h50);
    push_msg(0, 1, 8'h60);
    tick(2);
    dma_ack_n = 1'b0; tick(3);
    read_byte(1'b0, 8'h50, "R9 first message");
    read_byte(1'b0, 8'h51, "R9 first message");
    chk("R9 request high after first message", dma_req_n, 1'b1);
    tick(3);
    chk("R9 request held high while ack low", dma_req_n, 1'b1);
    dma_ack_n = 1'b1; tick(5);
    chk("R9 re-request for waiting message", dma_req_n, 1'b0);
    read_msg(1'b0, 8'h60, 1, "R9 second message");
  endtask

  task automatic t_chan_reset();
    wr_reg(C_EN | C_RST);
    tick(5);
    push_msg(0, 3, 8'h70);
    tick(2);
    dma_ack_n = 1'b0; tick(3);
    read_byte(1'b0, 8'h70, "R11 before reset");
    wr_reg(C_EN | C_RST);
    tick(3);
    chk("R11 steady 1 keeps transfer", dma_req_n, 1'b0);
    wr_reg(C_EN);
    wr_reg(C_EN | C_RST);
    tick(3);
    chk("R11 rising reset bit drops request", dma_req_n, 1'b1);
    tick(3);
    chk("R11 request stays high until ack release", dma_req_n, 1'b1);
    dma_ack_n = 1'b1; tick(5);
    chk("R11 request resumes after release", dma_req_n, 1'b0);
    read_msg(1'b0, 8'h71, 2, "R11 remainder");
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      wp[c] = 0; rp[c] = 0; nin[c] = 0; nout[c] = 0;
      for (int i = 0; i < 32; i++) begin mem[c][i] = 8'h00; lst[c][i] = 1'b0; end
    end
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
    dma_ack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_regs();
    t_disabled();
    t_partial();
    t_read_strobe();
    t_dir_mode();
    t_chan_sel();
    t_reserved();
    t_back_to_back();
    t_chan_reset();
    tick(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule